// File: doc/BRIEF.md
# Cartridge DMA Register Controller

This block sits on a 32-bit register port and drives byte-wide DMA in either direction between main DRAM and a cartridge address space. Software loads a DRAM address and a cartridge address, then writes one of two length registers. That write starts the copy. The two length registers differ only in direction. A built-in mover copies one byte per clock through simple byte ports. The elapsed transfer time is decided by an external timing block. It receives a start pulse together with the byte count, the direction and the cartridge start address, and it answers with a completion pulse.

The controller reports DMA busy until the copy has finished and the completion pulse has arrived, whichever of the two comes later. It then raises an interrupt-pending flag, which software clears through the status register. As soon as a transfer is launched, both address registers advance past it. The DRAM address is rounded up to an 8-byte boundary and the cartridge address is rounded up to an even value. Per-domain bus timing fields are held here for the external timing block and are also brought out as packed words.

Top module: `cdma_ctrl`

## Requirements
- R1: Offset 0x00 holds the DRAM address. Both writes and reads are masked with 0x00FFFFFE.
- R2: Offset 0x04 holds the 32-bit cartridge address. Bit 0 is forced to zero.
- R3: A write to offset 0x08 stores a 24-bit length and starts a DRAM-to-cartridge copy. A write to offset 0x0C stores a 24-bit length and starts a cartridge-to-DRAM copy. Each copy moves the stored value plus one bytes. Both length registers read back their stored value.
- R4: At launch, the DRAM address becomes (address + bytes) rounded up to a multiple of 8, kept to 24 bits.
- R5: At launch, the cartridge address becomes address + bytes, plus one more if that sum is odd, wrapping at 32 bits.
- R6: A read of offset 0x10 returns DMA busy in bit 0, the io_busy input in bit 1, zero in bit 2, interrupt pending in bit 3, and zero in all other bits.
- R7: DMA busy is set on the clock edge of the launch. It stays set until both the copy has ended and a completion pulse has been seen. A completion pulse that arrives while bytes are still moving is remembered.
- R8: When busy clears, the interrupt-pending flag is set. The irq output always equals that flag.
- R9: A write to offset 0x10 with bit 1 set clears the pending flag. A completion on the same edge takes precedence over the clear.
- R10: Offsets 0x14, 0x18, 0x1C and 0x20 hold the 8-bit domain-1 fields for latency, pulse width, page size and release. Offsets 0x24 to 0x30 hold the same four fields for domain 2. Each domain is output as {release, page, pulse, latency}.
- R11: Every other offset, including an offset that is not word aligned, reads as zero. Writes to those offsets change no register.
- R12: A length write while busy is ignored. The stored length, the addresses and the busy state are all left unchanged, and no transfer starts.
- R13: Starting one cycle after the launch, byte i of the copy is moved from source base + i to destination base + i, one byte per cycle. Only the destination write enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| io_busy | input | 1 | Single-access bus busy, reported in the status register |
| xfer_start | output | 1 | Pulse on the launch cycle |
| xfer_to_dram | output | 1 | Direction of the launched copy: 1 means cartridge to DRAM |
| xfer_bytes | output | 25 | Byte count of the launched copy |
| xfer_cart_addr | output | 32 | Cartridge start address of the launched copy |
| xfer_done | input | 1 | Completion pulse from the timing block |
| irq | output | 1 | Interrupt pending |
| dom1_timing | output | 32 | Domain-1 timing fields, packed |
| dom2_timing | output | 32 | Domain-2 timing fields, packed |
| mem_dram_addr | output | 24 | DRAM byte address |
| dram_rdata | input | 8 | DRAM read byte |
| dram_we | output | 1 | DRAM byte write enable |
| dram_wdata | output | 8 | DRAM write byte |
| mem_cart_addr | output | 32 | Cartridge byte address |
| cart_rdata | input | 8 | Cartridge read byte |
| cart_we | output | 1 | Cartridge byte write enable |
| cart_wdata | output | 8 | Cartridge write byte |

## Verification
The bound checker watches the following on every cycle:
- busy never drops without a completion event, and a launch always sets busy and activates the mover;
- a completion always raises the interrupt, and a clear always lowers it unless a completion falls on the same edge;
- no launch appears while busy, and the DRAM and cartridge write enables are never asserted together or outside busy;
- the fixed-zero bits of the address and status reads stay at zero.

Only the bench's scenarios can show that the bytes land at the right places, that the address registers advance with the right rounding and wrap-around, that an early completion pulse is honoured, and that ignored writes leave register contents unchanged.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  localparam int DRAM_AW  = 24;
  localparam int CART_AW  = 32;
  localparam int LEN_W    = 24;
  localparam int CNT_W    = LEN_W + 1;
  localparam int TF_W     = 8;
  localparam int NUM_DOM  = 2;
  localparam int TF_PER_DOM = 4;
  localparam int NUM_TF   = NUM_DOM * TF_PER_DOM;

  localparam logic [7:0] OFF_DRAM   = 8'h00;
  localparam logic [7:0] OFF_CART   = 8'h04;
  localparam logic [7:0] OFF_LEN_WR = 8'h08;
  localparam logic [7:0] OFF_LEN_RD = 8'h0C;
  localparam logic [7:0] OFF_STAT   = 8'h10;
  localparam logic [7:0] OFF_TIME0  = 8'h14;

  localparam logic [DRAM_AW-1:0] DRAM_MASK = 24'hFFFFFE;

  // DRAM pointer after a copy: advance, then round up to an 8-byte boundary.
  function automatic logic [DRAM_AW-1:0] dram_after(input logic [DRAM_AW-1:0] base,
                                                    input logic [CNT_W-1:0] bytes);
    logic [CNT_W:0] sum;
    sum = {2'b00, base} + {1'b0, bytes} + 26'd7;
    return sum[DRAM_AW-1:0] & ~24'h7;
  endfunction

  // Cartridge pointer after a copy: advance, then bump an odd result to even.
  function automatic logic [CART_AW-1:0] cart_after(input logic [CART_AW-1:0] base,
                                                    input logic [CNT_W-1:0] bytes);
    logic [CART_AW-1:0] sum;
    sum = base + {{(CART_AW-CNT_W){1'b0}}, bytes};
    return sum + {{(CART_AW-1){1'b0}}, sum[0]};
  endfunction

  // Byte count for a stored length value (value plus one).
  function automatic logic [CNT_W-1:0] len_to_bytes(input logic [LEN_W-1:0] len);
    return {1'b0, len} + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/cdma_regfile.sv
module cdma_regfile
  import cdma_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          addr,
  input  logic [31:0]         wdata,
  input  logic                launch,
  input  logic                launch_to_dram,
  input  logic [CNT_W-1:0]    launch_bytes,
  input  logic [3:0]          status_bits,
  output logic [31:0]         rdata,
  output logic [DRAM_AW-1:0]  dram_q,
  output logic [CART_AW-1:0]  cart_q,
  output logic [TF_PER_DOM*TF_W-1:0] dom1_q,
  output logic [TF_PER_DOM*TF_W-1:0] dom2_q
);
  logic [LEN_W-1:0] len_out_q;
  logic [LEN_W-1:0] len_in_q;
  logic [TF_W-1:0]  tfield_q [NUM_TF];

  // Address registers: software writes, or advance on launch.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dram_q <= '0;
      cart_q <= '0;
    end else if (launch) begin
      dram_q <= dram_after(dram_q, launch_bytes);
      cart_q <= cart_after(cart_q, launch_bytes);
    end else if (wr_en && addr == OFF_DRAM) begin
      dram_q <= wdata[DRAM_AW-1:0] & DRAM_MASK;
    end else if (wr_en && addr == OFF_CART) begin
      cart_q <= {wdata[CART_AW-1:1], 1'b0};
    end
  end

  // Length registers only capture on an accepted launch.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_out_q <= '0;
      len_in_q  <= '0;
    end else if (launch) begin
      if (launch_to_dram) len_in_q  <= wdata[LEN_W-1:0];
      else                len_out_q <= wdata[LEN_W-1:0];
    end
  end

  // Timing fields: one 8-bit register per word offset.
  for (genvar g = 0; g < NUM_TF; g++) begin : g_tf
    localparam logic [7:0] OFF = OFF_TIME0 + 8'(4 * g);
    always_ff @(posedge clk) begin
      if (!rst_n)                    tfield_q[g] <= '0;
      else if (wr_en && addr == OFF) tfield_q[g] <= wdata[TF_W-1:0];
    end
    if (g < TF_PER_DOM) begin : g_d1
      assign dom1_q[g*TF_W +: TF_W] = tfield_q[g];
    end else begin : g_d2
      assign dom2_q[(g-TF_PER_DOM)*TF_W +: TF_W] = tfield_q[g];
    end
  end

  // Read mux.
  always_comb begin
    rdata = '0;
    unique case (addr)
      OFF_DRAM:   rdata = {8'h00, dram_q & DRAM_MASK};
      OFF_CART:   rdata = cart_q;
      OFF_LEN_WR: rdata = {8'h00, len_out_q};
      OFF_LEN_RD: rdata = {8'h00, len_in_q};
      OFF_STAT:   rdata = {28'h0, status_bits};
      default: begin
        for (int i = 0; i < NUM_TF; i++) begin
          if (addr == OFF_TIME0 + 8'(4 * i)) rdata = {24'h0, tfield_q[i]};
        end
      end
    endcase
  end
endmodule

// File: rtl/cdma_mover.sv
module cdma_mover
  import cdma_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  logic                launch_to_dram,
  input  logic [DRAM_AW-1:0]  dram_base,
  input  logic [CART_AW-1:0]  cart_base,
  input  logic [CNT_W-1:0]    bytes,
  output logic                active,
  output logic [DRAM_AW-1:0]  mem_dram_addr,
  input  logic [7:0]          dram_rdata,
  output logic                dram_we,
  output logic [7:0]          dram_wdata,
  output logic [CART_AW-1:0]  mem_cart_addr,
  input  logic [7:0]          cart_rdata,
  output logic                cart_we,
  output logic [7:0]          cart_wdata
);
  logic               to_dram_q;
  logic [DRAM_AW-1:0] dram_ptr_q;
  logic [CART_AW-1:0] cart_ptr_q;
  logic [CNT_W-1:0]   left_q;
  logic               last_byte;

  assign last_byte = active && (left_q == {{(CNT_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      to_dram_q  <= 1'b0;
      dram_ptr_q <= '0;
      cart_ptr_q <= '0;
      left_q     <= '0;
    end else if (launch) begin
      active     <= 1'b1;
      to_dram_q  <= launch_to_dram;
      dram_ptr_q <= dram_base;
      cart_ptr_q <= cart_base;
      left_q     <= bytes;
    end else if (active) begin
      dram_ptr_q <= dram_ptr_q + 1'b1;
      cart_ptr_q <= cart_ptr_q + 1'b1;
      left_q     <= left_q - 1'b1;
      if (last_byte) active <= 1'b0;
    end
  end

  assign mem_dram_addr = dram_ptr_q;
  assign mem_cart_addr = cart_ptr_q;
  assign dram_we       = active && to_dram_q;
  assign cart_we       = active && !to_dram_q;
  assign dram_wdata    = cart_rdata;
  assign cart_wdata    = dram_rdata;
endmodule

// File: rtl/cdma_status.sv
module cdma_status (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic mover_active,
  input  logic xfer_done,
  input  logic clr_req,
  output logic dma_busy,
  output logic irq_pend,
  output logic finish_evt
);
  logic done_seen_q;

  assign finish_evt = dma_busy && !mover_active && (xfer_done || done_seen_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_busy    <= 1'b0;
      done_seen_q <= 1'b0;
      irq_pend    <= 1'b0;
    end else begin
      if (launch)          dma_busy <= 1'b1;
      else if (finish_evt) dma_busy <= 1'b0;

      if (finish_evt)                           done_seen_q <= 1'b0;
      else if (dma_busy && mover_active && xfer_done) done_seen_q <= 1'b1;

      if (finish_evt)   irq_pend <= 1'b1;
      else if (clr_req) irq_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/cdma_ctrl.sv
module cdma_ctrl
  import cdma_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [7:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 io_busy,
  output logic                 xfer_start,
  output logic                 xfer_to_dram,
  output logic [CNT_W-1:0]     xfer_bytes,
  output logic [CART_AW-1:0]   xfer_cart_addr,
  input  logic                 xfer_done,
  output logic                 irq,
  output logic [31:0]          dom1_timing,
  output logic [31:0]          dom2_timing,
  output logic [DRAM_AW-1:0]   mem_dram_addr,
  input  logic [7:0]           dram_rdata,
  output logic                 dram_we,
  output logic [7:0]           dram_wdata,
  output logic [CART_AW-1:0]   mem_cart_addr,
  input  logic [7:0]           cart_rdata,
  output logic                 cart_we,
  output logic [7:0]           cart_wdata
);
  logic               dma_busy;
  logic               finish_evt;
  logic               mover_active;
  logic               irq_pend;
  logic               len_hit;
  logic               launch_evt;
  logic               clr_req;
  logic [DRAM_AW-1:0] dram_q;
  logic [CART_AW-1:0] cart_q;

  // Named internal events.
  assign len_hit    = reg_wr && (reg_addr == OFF_LEN_WR || reg_addr == OFF_LEN_RD);
  assign launch_evt = len_hit && !dma_busy;
  assign clr_req    = reg_wr && reg_addr == OFF_STAT && reg_wdata[1];

  assign xfer_start     = launch_evt;
  assign xfer_to_dram   = (reg_addr == OFF_LEN_RD);
  assign xfer_bytes     = len_to_bytes(reg_wdata[LEN_W-1:0]);
  assign xfer_cart_addr = cart_q;
  assign irq            = irq_pend;

  cdma_regfile u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (reg_wr),
    .addr           (reg_addr),
    .wdata          (reg_wdata),
    .launch         (launch_evt),
    .launch_to_dram (xfer_to_dram),
    .launch_bytes   (xfer_bytes),
    .status_bits    ({irq_pend, 1'b0, io_busy, dma_busy}),
    .rdata          (reg_rdata),
    .dram_q         (dram_q),
    .cart_q         (cart_q),
    .dom1_q         (dom1_timing),
    .dom2_q         (dom2_timing)
  );

  cdma_mover u_mover (
    .clk            (clk),
    .rst_n          (rst_n),
    .launch         (launch_evt),
    .launch_to_dram (xfer_to_dram),
    .dram_base      (dram_q),
    .cart_base      (cart_q),
    .bytes          (xfer_bytes),
    .active         (mover_active),
    .mem_dram_addr  (mem_dram_addr),
    .dram_rdata     (dram_rdata),
    .dram_we        (dram_we),
    .dram_wdata     (dram_wdata),
    .mem_cart_addr  (mem_cart_addr),
    .cart_rdata     (cart_rdata),
    .cart_we        (cart_we),
    .cart_wdata     (cart_wdata)
  );

  cdma_status u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch_evt),
    .mover_active (mover_active),
    .xfer_done    (xfer_done),
    .clr_req      (clr_req),
    .dma_busy     (dma_busy),
    .irq_pend     (irq_pend),
    .finish_evt   (finish_evt)
  );
endmodule

// File: rtl/cdma_ctrl_chk.sv
module cdma_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dma_busy,
  input logic        finish_evt,
  input logic        launch_evt,
  input logic        mover_active,
  input logic        clr_req,
  input logic        irq,
  input logic        xfer_start,
  input logic        dram_we,
  input logic        cart_we,
  input logic [7:0]  reg_addr,
  input logic [31:0] reg_rdata
);
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_busy && !finish_evt |=> dma_busy);
  p_launch_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    launch_evt |=> dma_busy && mover_active);
  p_launch_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !dma_busy);
  p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> irq && !dma_busy);
  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !finish_evt |=> !irq);
  p_one_side_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(dram_we && cart_we));
  p_write_in_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_we || cart_we) |-> dma_busy);
  p_status_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 8'h10 |-> reg_rdata[31:4] == 28'h0 && !reg_rdata[2]);
  p_dram_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 8'h00 |-> reg_rdata[31:24] == 8'h00 && !reg_rdata[0]);
endmodule

bind cdma_ctrl cdma_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dma_busy     (dma_busy),
  .finish_evt   (finish_evt),
  .launch_evt   (launch_evt),
  .mover_active (mover_active),
  .clr_req      (clr_req),
  .irq          (irq),
  .xfer_start   (xfer_start),
  .dram_we      (dram_we),
  .cart_we      (cart_we),
  .reg_addr     (reg_addr),
  .reg_rdata    (reg_rdata)
);

// File: tb/cdma_ctrl_test.sv
module cdma_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;
  // {offset, write data, expected read}
  localparam logic [71:0] VECS [NVEC] = '{
    {8'h00, 32'hFFFFFFFF, 32'h00FFFFFE},
    {8'h00, 32'h00000011, 32'h00000010},
    {8'h04, 32'h12345677, 32'h12345676},
    {8'h14, 32'h000001AB, 32'h000000AB},
    {8'h18, 32'h00000022, 32'h00000022},
    {8'h1C, 32'h00000033, 32'h00000033},
    {8'h20, 32'h00000044, 32'h00000044},
    {8'h24, 32'h00000055, 32'h00000055},
    {8'h28, 32'h00000066, 32'h00000066},
    {8'h2C, 32'h00000077, 32'h00000077},
    {8'h30, 32'h00000F88, 32'h00000088},
    {8'h34, 32'hFFFFFFFF, 32'h00000000},
    {8'h02, 32'hFFFFFFFF, 32'h00000000}
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        io_busy = 0;
  logic        xfer_start, xfer_to_dram;
  logic [24:0] xfer_bytes;
  logic [31:0] xfer_cart_addr;
  logic        xfer_done = 0;
  logic        irq;
  logic [31:0] dom1_timing, dom2_timing;
  logic [23:0] mem_dram_addr;
  logic [7:0]  dram_rdata, dram_wdata, cart_rdata, cart_wdata;
  logic        dram_we, cart_we;
  logic [31:0] mem_cart_addr;
  logic [7:0]  dram_mem [256];
  logic [7:0]  cart_mem [256];
  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign dram_rdata = dram_mem[mem_dram_addr[7:0]];
  assign cart_rdata = cart_mem[mem_cart_addr[7:0]];
  always @(posedge clk) begin
    if (dram_we) dram_mem[mem_dram_addr[7:0]] <= dram_wdata;
    if (cart_we) cart_mem[mem_cart_addr[7:0]] <= cart_wdata;
  end

  cdma_ctrl uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    xfer_done = 1;
    @(negedge clk);
    xfer_done = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      dram_mem[i] = 8'(i * 7 + 3);
      cart_mem[i] = 8'(i ^ 8'h5A);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // Reset state
    rd(8'h00, rv); check("R1 reset dram", rv, 32'h0);
    rd(8'h10, rv); check("R6 reset status", rv, 32'h0);
    check("R8 reset irq", {31'h0, irq}, 32'h0);

    // Register vector walk
    for (int v = 0; v < NVEC; v++) begin
      wr(VECS[v][71:64], VECS[v][63:32]);
      rd(VECS[v][71:64], rv);
      check($sformatf("R1 R2 R10 R11 vector %0d", v), rv, VECS[v][31:0]);
    end
    rd(8'h04, rv); check("R11 cart untouched", rv, 32'h12345676);
    check("R10 dom1 pack", dom1_timing, 32'h443322AB);
    check("R10 dom2 pack", dom2_timing, 32'h88776655);

    // io_busy reflection
    io_busy = 1;
    rd(8'h10, rv); check("R6 io busy bit", rv, 32'h2);
    io_busy = 0;

    // DRAM -> cart, 5 bytes, late completion
    wr(8'h00, 32'h10);
    wr(8'h04, 32'h40);
    wr(8'h08, 32'h4);
    rd(8'h10, rv); check("R7 busy after launch", rv, 32'h1);
    rd(8'h00, rv); check("R4 dram advance", rv, 32'h18);
    rd(8'h04, rv); check("R5 cart advance", rv, 32'h46);
    rd(8'h08, rv); check("R3 len readback", rv, 32'h4);
    repeat (6) @(negedge clk);
    rd(8'h10, rv); check("R7 busy held until done", rv, 32'h1);
    for (int i = 0; i < 5; i++)
      check("R13 R3 cart bytes", {24'h0, cart_mem[8'h40 + i]}, {24'h0, dram_mem[8'h10 + i]});
    check("R3 no extra byte", {24'h0, cart_mem[8'h45]}, {24'h0, 8'(8'h45 ^ 8'h5A)});
    pulse_done();
    rd(8'h10, rv); check("R8 done sets irq", rv, 32'h8);
    check("R8 irq port", {31'h0, irq}, 32'h1);
    wr(8'h10, 32'h1);
    rd(8'h10, rv); check("R9 bit0 write no clear", rv, 32'h8);
    wr(8'h10, 32'h2);
    rd(8'h10, rv); check("R9 clear", rv, 32'h0);

    // Cart -> DRAM, 3 bytes, early completion
    wr(8'h0C, 32'h2);
    pulse_done();
    repeat (5) @(negedge clk);
    rd(8'h10, rv); check("R7 early done remembered", rv, 32'h8);
    for (int i = 0; i < 3; i++)
      check("R13 R3 dram bytes", {24'h0, dram_mem[8'h18 + i]}, {24'h0, cart_mem[8'h46 + i]});
    rd(8'h00, rv); check("R4 dram second", rv, 32'h20);
    rd(8'h04, rv); check("R5 cart second", rv, 32'h4A);
    wr(8'h10, 32'h2);

    // Wrap-around
    wr(8'h00, 32'h00FFFFF8);
    wr(8'h04, 32'hFFFFFFFE);
    wr(8'h08, 32'h2);
    rd(8'h00, rv); check("R4 dram wrap", rv, 32'h0);
    rd(8'h04, rv); check("R5 cart odd wrap", rv, 32'h2);

    // Launch while busy is ignored
    wr(8'h0C, 32'h55);
    rd(8'h0C, rv); check("R12 len unchanged", rv, 32'h2);
    rd(8'h00, rv); check("R12 dram unchanged", rv, 32'h0);
    repeat (4) @(negedge clk);
    pulse_done();
    rd(8'h10, rv); check("R12 single completion", rv, 32'h8);

    // Completion and clear on the same edge: completion wins
    wr(8'h10, 32'h2);
    wr(8'h08, 32'h0);
    repeat (3) @(negedge clk);
    @(negedge clk);
    xfer_done = 1; reg_wr = 1; reg_addr = 8'h10; reg_wdata = 32'h2;
    @(negedge clk);
    xfer_done = 0; reg_wr = 0;
    rd(8'h10, rv); check("R9 completion beats clear", rv, 32'h8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule